// File: doc/BRIEF.md
# Triple-Voted Storage Upset Checker

This block measures how often stored bits get corrupted, using triple modular redundancy on the storage it exercises. A start pulse launches a run in one of three storage modes. Each run writes words whose values come from a counter that restarts at zero, reads them back through a bitwise two-of-three voter, and compares the voted word with the value the counter says was written. Two tallies come out of every run. One counts compares where the voter masked a disagreement among the copies. The other counts compares where the voted word itself was wrong.

The `upset_pat` input holds one XOR mask per copy, so a test can place bit flips on chosen copies at known points. In triple-register mode the masks corrupt the three stored copies as they are written. In repeated-read mode they corrupt the three reads of a single stored word. In FIFO mode they corrupt the three copies of the storage array as each word is written. The FIFO read and write pointers are also kept in three copies. They are voted and rewritten on every cycle, and the full and empty flags come from the voted pointers.

Top module: `tmr_store_check`

## Requirements
- R1: After reset `busy`, `done`, `fifo_full` and both counters are 0, and `fifo_empty` is 1.
- R2: The voter output is the bitwise majority of its three inputs. A compare whose voted word equals the expected value, while at least one input differs from the voted word, adds 1 to `corr_cnt`.
- R3: A compare whose voted word differs from the expected value adds 1 to `uncorr_cnt` and leaves `corr_cnt` unchanged. No compare changes both counters.
- R4: Mode 0 (triple register) runs RUN_LEN iterations of two cycles each. Each iteration writes copy k as the data XOR mask k, where mask k is `upset_pat[k*W +: W]`, and then votes the three copies against the data.
- R5: Mode 1 (repeated read) runs RUN_LEN iterations of four cycles each. Each iteration writes the data into one register and reads it three times, with read k XORed with mask k, and then votes the three reads.
- R6: Modes 2 and 3 (FIFO) fill the FIFO with DEPTH words, copy k of each word XORed with mask k, and then drain it in write order, voting each word against the counter. The run takes 2*DEPTH+2 cycles, `fifo_full` is seen high during it, and `fifo_empty` is 1 at its end.
- R7: `fifo_full` and `fifo_empty` are derived from the voted pointer copies and are never high together.
- R8: A `start` while `busy` is 1 is ignored. The run continues unchanged and the counters are not cleared. An accepted `start` clears both counters and restarts the data counter at 0.
- R9: `done` is a one-cycle pulse in the first idle cycle after a run, and `busy` is 0 while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when idle |
| mode | input | 2 | 0 triple register, 1 repeated read, 2 or 3 FIFO |
| upset_pat | input | 3*W | Per-copy XOR masks; mask k at bits k*W +: W |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fifo_full | output | 1 | Voted FIFO full flag |
| fifo_empty | output | 1 | Voted FIFO empty flag |
| corr_cnt | output | CNT_W | Compares corrected by the voter |
| uncorr_cnt | output | CNT_W | Compares with a wrong voted word |

## Verification
The bench targets masks that flip different bits in different copies. Bitwise voting must correct these, so a voter that compared whole words would report them as uncorrectable. It also uses overlapping masks whose majority leaves a single bad bit, which a design that only checked for copy agreement would count as corrected. Draining the FIFO with clean masks catches pointer or ordering faults, because a word read from the wrong slot shows up as uncorrectable. A start pulse in the middle of a run catches a design that restarts the run or clears its counters while busy. Run lengths are measured in cycles for each mode, which exposes a missing or extra read or fill step.

// File: rtl/tmr_store_check.sv
module tmr_store_check #(
  parameter int W       = 8,
  parameter int RUN_LEN = 6,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [3*W-1:0]   upset_pat,
  output logic             busy,
  output logic             done,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic [CNT_W-1:0] corr_cnt,
  output logic [CNT_W-1:0] uncorr_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(RUN_LEN + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_AWR, S_ARD, S_BWR, S_BR1, S_BR2, S_BR3, S_FILL, S_DRAIN
  } st_t;

  st_t st;
  logic [W-1:0]  r0, r1, r2, seq, exp_v;
  logic [IW-1:0] iter;
  logic [AW:0]   wp [3];
  logic [AW:0]   rp [3];
  logic [AW:0]   wpv, rpv;
  logic [W-1:0]  m0 [DEPTH];
  logic [W-1:0]  m1 [DEPTH];
  logic [W-1:0]  m2 [DEPTH];
  logic [W-1:0]  p0, p1, p2;
  logic [W-1:0]  ca, cb, cc, cexp, vote;
  logic          cmp_en, mism, disagree, push, pop, last_it;

  assign p0 = upset_pat[0 +: W];
  assign p1 = upset_pat[W +: W];
  assign p2 = upset_pat[2*W +: W];

  assign wpv = (wp[0] & wp[1]) | (wp[1] & wp[2]) | (wp[0] & wp[2]);
  assign rpv = (rp[0] & rp[1]) | (rp[1] & rp[2]) | (rp[0] & rp[2]);
  assign fifo_full  = (wpv[AW] != rpv[AW]) && (wpv[AW-1:0] == rpv[AW-1:0]);
  assign fifo_empty = (wpv == rpv);
  assign push = (st == S_FILL) && !fifo_full;
  assign pop  = (st == S_DRAIN) && !fifo_empty;
  assign busy = (st != S_IDLE);
  assign last_it = (iter == IW'(RUN_LEN - 1));

  always_comb begin
    cmp_en = 1'b0;
    ca = r0; cb = r1; cc = r2; cexp = seq;
    case (st)
      S_ARD:   cmp_en = 1'b1;
      S_BR3: begin
        cmp_en = 1'b1;
        ca = r1; cb = r2; cc = r0 ^ p2;
      end
      S_DRAIN: begin
        cmp_en = pop;
        ca = m0[rpv[AW-1:0]]; cb = m1[rpv[AW-1:0]]; cc = m2[rpv[AW-1:0]];
        cexp = exp_v;
      end
      default: ;
    endcase
  end

  assign vote     = (ca & cb) | (cb & cc) | (ca & cc);
  assign mism     = (vote != cexp);
  assign disagree = (ca != vote) || (cb != vote) || (cc != vote);

  always_ff @(posedge clk) begin
    if (push) begin
      m0[wpv[AW-1:0]] <= seq ^ p0;
      m1[wpv[AW-1:0]] <= seq ^ p1;
      m2[wpv[AW-1:0]] <= seq ^ p2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      seq <= '0; exp_v <= '0; iter <= '0;
      r0 <= '0; r1 <= '0; r2 <= '0;
      corr_cnt <= '0; uncorr_cnt <= '0;
      for (int i = 0; i < 3; i++) begin
        wp[i] <= '0;
        rp[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        wp[i] <= wpv + {{AW{1'b0}}, push};
        rp[i] <= rpv + {{AW{1'b0}}, pop};
      end
      if (cmp_en) begin
        if (mism) uncorr_cnt <= uncorr_cnt + 1'b1;
        else if (disagree) corr_cnt <= corr_cnt + 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          corr_cnt <= '0; uncorr_cnt <= '0;
          seq <= '0; exp_v <= '0; iter <= '0;
          for (int i = 0; i < 3; i++) begin
            wp[i] <= '0;
            rp[i] <= '0;
          end
          st <= mode[1] ? S_FILL : (mode[0] ? S_BWR : S_AWR);
        end
        S_AWR: begin
          r0 <= seq ^ p0; r1 <= seq ^ p1; r2 <= seq ^ p2;
          st <= S_ARD;
        end
        S_BWR: begin
          r0 <= seq;
          st <= S_BR1;
        end
        S_BR1: begin
          r1 <= r0 ^ p0;
          st <= S_BR2;
        end
        S_BR2: begin
          r2 <= r0 ^ p1;
          st <= S_BR3;
        end
        S_ARD, S_BR3: begin
          seq <= seq + 1'b1;
          if (last_it) begin
            st <= S_IDLE;
            done <= 1'b1;
          end else begin
            iter <= iter + 1'b1;
            st <= (st == S_ARD) ? S_AWR : S_BWR;
          end
        end
        S_FILL: begin
          if (fifo_full) st <= S_DRAIN;
          else seq <= seq + 1'b1;
        end
        S_DRAIN: begin
          if (fifo_empty) begin
            st <= S_IDLE;
            done <= 1'b1;
          end else exp_v <= exp_v + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tmr_store_check_sva.sv
module tmr_store_check_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [CNT_W-1:0] corr_cnt,
  input logic [CNT_W-1:0] uncorr_cnt
);
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_corr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (corr_cnt == $past(corr_cnt) || corr_cnt == $past(corr_cnt) + 1'b1));

  p_uncorr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (uncorr_cnt == $past(uncorr_cnt) || uncorr_cnt == $past(uncorr_cnt) + 1'b1));

  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !(corr_cnt != $past(corr_cnt) && uncorr_cnt != $past(uncorr_cnt)));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && corr_cnt != '0) |=> corr_cnt != '0);
endmodule

bind tmr_store_check tmr_store_check_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .corr_cnt(corr_cnt), .uncorr_cnt(uncorr_cnt)
);

// File: tb/tmr_store_check_test.sv
module tmr_store_check_test;
  localparam int W = 8, RUN_LEN = 6, DEPTH = 8, CNT_W = 16;
  localparam int NV = 13;
  localparam logic [25:0] VECS [NV] = '{
    {2'd0, 8'h00, 8'h00, 8'h00},
    {2'd0, 8'h00, 8'h00, 8'h01},
    {2'd0, 8'h00, 8'h80, 8'h00},
    {2'd0, 8'h00, 8'h0F, 8'h0F},
    {2'd0, 8'h04, 8'h02, 8'h01},
    {2'd0, 8'h00, 8'h06, 8'h03},
    {2'd1, 8'hFF, 8'h00, 8'h00},
    {2'd1, 8'h10, 8'h10, 8'h10},
    {2'd1, 8'h00, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h20, 8'h00},
    {2'd2, 8'hAA, 8'h55, 8'h55},
    {2'd3, 8'h00, 8'h00, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3*W-1:0] upset_pat = '0;
  logic busy, done, fifo_full, fifo_empty;
  logic [CNT_W-1:0] corr_cnt, uncorr_cnt;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  tmr_store_check #(.W(W), .RUN_LEN(RUN_LEN), .DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .upset_pat(upset_pat),
    .busy(busy), .done(done), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .corr_cnt(corr_cnt), .uncorr_cnt(uncorr_cnt));

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] maj3(input logic [W-1:0] a, b, c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  task automatic run_one(input logic [1:0] md, input logic [3*W-1:0] pat, input bit mid_start);
    int cyc = 0, wd = 0, n;
    bit full_seen = 0;
    logic [W-1:0] m;
    int ec, eu, ecyc;
    @(negedge clk);
    mode = md; upset_pat = pat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (busy) cyc++;
      if (fifo_full) full_seen = 1;
      if (mid_start && cyc == 3) begin
        start = 1'b1; mode = 2'd2;
      end else start = 1'b0;
      @(negedge clk);
      wd++;
      if (wd > 1000) begin
        chk("watchdog", 1, 0);
        break;
      end
    end
    start = 1'b0;
    n = md[1] ? DEPTH : RUN_LEN;
    m = maj3(pat[0 +: W], pat[W +: W], pat[2*W +: W]);
    eu = (m != 0) ? n : 0;
    ec = (m == 0 && pat != 0) ? n : 0;
    ecyc = md[1] ? 2*DEPTH + 2 : (md[0] ? 4*RUN_LEN : 2*RUN_LEN);
    chk("R2 corrected count", int'(corr_cnt), ec);
    chk("R3 uncorrectable count", int'(uncorr_cnt), eu);
    chk(md[1] ? "R6 run cycles" : (md[0] ? "R5 run cycles" : "R4 run cycles"), cyc, ecyc);
    chk("R6 full seen", int'(full_seen), int'(md[1]));
    chk("R7 empty at end", int'(fifo_empty), 1);
    @(negedge clk);
    chk("R9 done pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 corr", int'(corr_cnt), 0);
    chk("R1 uncorr", int'(uncorr_cnt), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      run_one(VECS[i][25:24], VECS[i][23:0], 1'b0);
    // R8: start pulse mid-run must not restart or clear
    run_one(2'd0, 24'h000001, 1'b1);
    // R8: accepted start clears counters from prior uncorrectable run
    run_one(2'd0, 24'h000F0F, 1'b0);
    run_one(2'd1, 24'h000000, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule